// File: doc/BRIEF.md
# Single-Beat Bus Write Master with Address-Timeout Recovery

This block turns one user write command into one 32-bit write on a shared-bus master port. The user presents an address, byte enables, a transfer type and a lock qualifier with a request strobe. The block acknowledges the command and raises the bus request with those qualifiers. It takes exactly one data word from a framed streaming source that uses active-low handshakes. It drives that word during the data phase and reports completion to the user once the bus acknowledges the write.

The bus can refuse the address phase by signalling a timeout. In that case the block withdraws the request and every qualifier on the next clock. It returns a timeout status together with completion to the user. If the streaming frame has not yet delivered its word, it ends the frame with a one-cycle discontinue. It also sets a master error flag that only reset clears. A write error response on the data acknowledge sets the same flag.

Top module: `wr_master_tmo`

## Requirements
- R1: While rst_ni is low and in the cycle after its release, bus_req_o, all bus qualifiers, bus_wrdata_o, mst_err_o and the four command pulses are 0, and st_dst_rdy_no and st_dst_dsc_no are 1.
- R2: A cmd_req_i sampled high while idle gives, in the next cycle, a one-cycle cmd_ack_o and bus_req_o high with bus_addr_o, bus_be_o, bus_type_o and bus_lock_o equal to the command values.
- R3: bus_req_o and its qualifiers stay unchanged while neither bus_addr_ack_i nor bus_tmo_i is sampled high.
- R4: bus_tmo_i sampled high while bus_req_o is high makes bus_req_o, bus_addr_o, bus_be_o, bus_type_o and bus_lock_o all 0 in the next cycle.
- R5: The same timeout raises cmd_done_o, cmd_tmo_o and cmd_err_o together for exactly the next cycle.
- R6: mst_err_o rises in the cycle after a timeout and stays 1 until rst_ni is asserted.
- R7: If the stream word has not been taken when the timeout is sampled, st_dst_dsc_no is 0 for exactly the next cycle; if it has been taken, st_dst_dsc_no stays 1.
- R8: A stream word is taken on a clock where st_src_rdy_ni and st_dst_rdy_no are both 0. st_dst_rdy_no is 0 only while a command is open and its word is not yet taken, so at most one word is taken per command.
- R9: After the address acknowledge, bus_wrdata_o carries the taken word. The write completes on a bus_wr_ack_i sampled while the word is held, giving a one-cycle cmd_done_o with cmd_err_o and cmd_tmo_o at 0. A bus_wr_ack_i sampled before the word is held is ignored.
- R10: A completing bus_wr_ack_i with bus_wr_err_i high gives cmd_done_o and cmd_err_o in the next cycle, with cmd_tmo_o at 0, and sets mst_err_o.
- R11: During the timeout recovery cycle and the idle cycle after it, cmd_ack_o stays 0 even if cmd_req_i is high; the pending command is accepted one cycle later.
- R12: If bus_tmo_i and bus_addr_ack_i are sampled high together, the timeout path of R4 and R5 is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; the only clear of the error flag |
| cmd_req_i | input | 1 | User write command strobe |
| cmd_addr_i | input | AW | Command address |
| cmd_be_i | input | DW/8 | Command byte enables |
| cmd_type_i | input | TW | Command transfer type |
| cmd_lock_i | input | 1 | Command bus lock qualifier |
| cmd_ack_o | output | 1 | Command accepted pulse |
| cmd_done_o | output | 1 | Command finished pulse |
| cmd_err_o | output | 1 | Command finished with error pulse |
| cmd_tmo_o | output | 1 | Command finished by address timeout pulse |
| st_data_i | input | DW | Stream write word |
| st_src_rdy_ni | input | 1 | Stream source ready, active low |
| st_dst_rdy_no | output | 1 | Stream destination ready, active low |
| st_dst_dsc_no | output | 1 | Stream destination discontinue, active low |
| bus_req_o | output | 1 | Bus request |
| bus_addr_o | output | AW | Bus address |
| bus_be_o | output | DW/8 | Bus byte enables |
| bus_type_o | output | TW | Bus transfer type |
| bus_lock_o | output | 1 | Bus lock |
| bus_wrdata_o | output | DW | Bus write data |
| bus_addr_ack_i | input | 1 | Address phase acknowledge |
| bus_tmo_i | input | 1 | Address phase timeout |
| bus_wr_ack_i | input | 1 | Write data acknowledge |
| bus_wr_err_i | input | 1 | Write error, valid with bus_wr_ack_i |
| mst_err_o | output | 1 | Sticky master error flag |

## Verification
The properties assume the bus behaves as a well-formed slave. bus_tmo_i and bus_addr_ack_i are raised only while bus_req_o is high, each for a single cycle. bus_wr_ack_i comes only after an address acknowledge. The stimulus pulses every bus response for exactly one cycle and only in those phases. The one exception is a deliberate early bus_wr_ack_i before the stream word is held, which exercises the ignore rule of R9. Commands may be held high across the recovery window on purpose, because the block is required to ignore them there.

// File: rtl/wrm_pkg.sv
package wrm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DATA  = 2'd2,
    PH_RECOV = 2'd3
  } wrm_phase_e;
endpackage

// File: rtl/wrm_err.sv
module wrm_err (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic err_o
);
  // sticky: only reset clears
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_o <= 1'b0;
    else if (set_i) err_o <= 1'b1;
  end
endmodule

// File: rtl/wrm_stream.sv
module wrm_stream #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          open_i,
  input  logic          abort_i,
  input  logic          idle_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          st_src_rdy_ni,
  output logic          st_dst_rdy_no,
  output logic          st_dst_dsc_no,
  output logic          have_o,
  output logic [DW-1:0] data_o
);
  logic take;

  assign st_dst_rdy_no = !(open_i && !have_o);
  assign st_dst_dsc_no = !(abort_i && !have_o);
  assign take          = open_i && !have_o && !st_src_rdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_o <= 1'b0;
      data_o <= '0;
    end else if (idle_i) begin
      have_o <= 1'b0;
    end else if (take) begin
      have_o <= 1'b1;
      data_o <= st_data_i;
    end
  end
endmodule

// File: rtl/wrm_ctrl.sv
module wrm_ctrl
  import wrm_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned BEW = 4,
  parameter int unsigned TW  = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_req_i,
  input  logic [AW-1:0]  cmd_addr_i,
  input  logic [BEW-1:0] cmd_be_i,
  input  logic [TW-1:0]  cmd_type_i,
  input  logic           cmd_lock_i,
  input  logic           bus_addr_ack_i,
  input  logic           bus_tmo_i,
  input  logic           bus_wr_ack_i,
  input  logic           bus_wr_err_i,
  input  logic           have_i,
  output wrm_phase_e     phase_o,
  output logic           err_set_o,
  output logic           cmd_ack_o,
  output logic           cmd_done_o,
  output logic           cmd_tmo_o,
  output logic           cmd_err_o,
  output logic [AW-1:0]  addr_o,
  output logic [BEW-1:0] be_o,
  output logic [TW-1:0]  type_o,
  output logic           lock_o
);
  wrm_phase_e phase_d;
  logic tmo_hit, wr_fin, accept;

  assign accept  = (phase_o == PH_IDLE) && cmd_req_i;
  assign tmo_hit = (phase_o == PH_ADDR) && bus_tmo_i;
  // data phase needs the stream word in hand before the ack counts
  assign wr_fin  = (phase_o == PH_DATA) && bus_wr_ack_i && have_i;
  assign err_set_o = tmo_hit || (wr_fin && bus_wr_err_i);

  always_comb begin
    phase_d = phase_o;
    unique case (phase_o)
      PH_IDLE:  if (cmd_req_i) phase_d = PH_ADDR;
      PH_ADDR: begin
        if (bus_tmo_i)           phase_d = PH_RECOV;
        else if (bus_addr_ack_i) phase_d = PH_DATA;
      end
      PH_DATA:  if (wr_fin) phase_d = PH_IDLE;
      PH_RECOV: phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o    <= PH_IDLE;
      cmd_ack_o  <= 1'b0;
      cmd_done_o <= 1'b0;
      cmd_tmo_o  <= 1'b0;
      cmd_err_o  <= 1'b0;
      addr_o     <= '0;
      be_o       <= '0;
      type_o     <= '0;
      lock_o     <= 1'b0;
    end else begin
      phase_o    <= phase_d;
      cmd_ack_o  <= accept;
      cmd_done_o <= tmo_hit || wr_fin;
      cmd_tmo_o  <= tmo_hit;
      cmd_err_o  <= tmo_hit || (wr_fin && bus_wr_err_i);
      if (accept) begin
        addr_o <= cmd_addr_i;
        be_o   <= cmd_be_i;
        type_o <= cmd_type_i;
        lock_o <= cmd_lock_i;
      end
    end
  end
endmodule

// File: rtl/wr_master_tmo.sv
module wr_master_tmo
  import wrm_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 3,
  localparam int unsigned BEW = DW / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_req_i,
  input  logic [AW-1:0]  cmd_addr_i,
  input  logic [BEW-1:0] cmd_be_i,
  input  logic [TW-1:0]  cmd_type_i,
  input  logic           cmd_lock_i,
  output logic           cmd_ack_o,
  output logic           cmd_done_o,
  output logic           cmd_err_o,
  output logic           cmd_tmo_o,
  input  logic [DW-1:0]  st_data_i,
  input  logic           st_src_rdy_ni,
  output logic           st_dst_rdy_no,
  output logic           st_dst_dsc_no,
  output logic           bus_req_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [BEW-1:0] bus_be_o,
  output logic [TW-1:0]  bus_type_o,
  output logic           bus_lock_o,
  output logic [DW-1:0]  bus_wrdata_o,
  input  logic           bus_addr_ack_i,
  input  logic           bus_tmo_i,
  input  logic           bus_wr_ack_i,
  input  logic           bus_wr_err_i,
  output logic           mst_err_o
);
  wrm_phase_e     phase;
  logic           err_set, have;
  logic [DW-1:0]  beat;
  logic [AW-1:0]  addr_q;
  logic [BEW-1:0] be_q;
  logic [TW-1:0]  type_q;
  logic           lock_q;

  wrm_ctrl #(.AW(AW), .BEW(BEW), .TW(TW)) i_ctrl (
    .clk_i, .rst_ni, .cmd_req_i, .cmd_addr_i, .cmd_be_i, .cmd_type_i, .cmd_lock_i,
    .bus_addr_ack_i, .bus_tmo_i, .bus_wr_ack_i, .bus_wr_err_i,
    .have_i(have), .phase_o(phase), .err_set_o(err_set),
    .cmd_ack_o, .cmd_done_o, .cmd_tmo_o, .cmd_err_o,
    .addr_o(addr_q), .be_o(be_q), .type_o(type_q), .lock_o(lock_q)
  );

  wrm_stream #(.DW(DW)) i_stream (
    .clk_i, .rst_ni,
    .open_i (phase == PH_ADDR || phase == PH_DATA),
    .abort_i(phase == PH_RECOV),
    .idle_i (phase == PH_IDLE),
    .st_data_i, .st_src_rdy_ni, .st_dst_rdy_no, .st_dst_dsc_no,
    .have_o(have), .data_o(beat)
  );

  wrm_err i_err (.clk_i, .rst_ni, .set_i(err_set), .err_o(mst_err_o));

  // qualifiers are forced to zero whenever the request is down
  assign bus_req_o    = (phase == PH_ADDR);
  assign bus_addr_o   = bus_req_o ? addr_q : '0;
  assign bus_be_o     = bus_req_o ? be_q   : '0;
  assign bus_type_o   = bus_req_o ? type_q : '0;
  assign bus_lock_o   = bus_req_o ? lock_q : 1'b0;
  assign bus_wrdata_o = (phase == PH_DATA) ? beat : '0;
endmodule

// File: rtl/wrm_checker.sv
module wrm_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned TW = 3,
  localparam int unsigned BEW = DW / 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmd_req_i,
  input logic           cmd_ack_o,
  input logic           cmd_done_o,
  input logic           cmd_err_o,
  input logic           cmd_tmo_o,
  input logic           st_dst_rdy_no,
  input logic           st_dst_dsc_no,
  input logic           bus_req_o,
  input logic [AW-1:0]  bus_addr_o,
  input logic [BEW-1:0] bus_be_o,
  input logic           bus_addr_ack_i,
  input logic           bus_tmo_i,
  input logic           mst_err_o
);
  p_ack_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ack_o |-> bus_req_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_tmo_i && !bus_addr_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o));

  p_tmo_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_tmo_i |=> !bus_req_o && bus_addr_o == '0 && bus_be_o == '0);

  p_tmo_status_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_tmo_i |=> cmd_done_o && cmd_tmo_o && cmd_err_o);

  p_tmo_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_tmo_o |=> !cmd_tmo_o);

  p_err_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_tmo_i |=> mst_err_o);

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_err_o |=> mst_err_o);

  p_dsc_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_dst_dsc_no |=> st_dst_dsc_no);

  p_dsc_tmo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_dst_dsc_no |-> cmd_tmo_o && st_dst_rdy_no);

  p_no_ack_recov_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_tmo_o |-> !cmd_ack_o);

  p_no_ack_after_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_tmo_o |=> !cmd_ack_o);

  p_tmo_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_tmo_i && bus_addr_ack_i |=> cmd_tmo_o);

  logic unused_req;
  assign unused_req = cmd_req_i;
endmodule

bind wr_master_tmo wrm_checker #(.AW(AW), .DW(DW), .TW(TW)) i_chk (
  .clk_i, .rst_ni, .cmd_req_i, .cmd_ack_o, .cmd_done_o, .cmd_err_o, .cmd_tmo_o,
  .st_dst_rdy_no, .st_dst_dsc_no, .bus_req_o, .bus_addr_o, .bus_be_o,
  .bus_addr_ack_i, .bus_tmo_i, .mst_err_o
);

// File: tb/test_wr_master_tmo.sv
module test_wr_master_tmo;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, TW = 3, BEW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_req = 0, cmd_lock = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [BEW-1:0] cmd_be = '0;
  logic [TW-1:0] cmd_type = '0;
  logic [DW-1:0] st_data = '0;
  logic st_src_rdy_n = 1'b1;
  logic addr_ack = 0, tmo = 0, wr_ack = 0, wr_err = 0;
  logic cmd_ack, cmd_done, cmd_err, cmd_tmo, dst_rdy_n, dst_dsc_n;
  logic bus_req, bus_lock, mst_err;
  logic [AW-1:0] bus_addr;
  logic [BEW-1:0] bus_be;
  logic [TW-1:0] bus_type;
  logic [DW-1:0] bus_wrdata;

  int errs = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wr_master_tmo #(.AW(AW), .DW(DW), .TW(TW)) i_wr_master_tmo (
    .clk_i(clk), .rst_ni(rst_n), .cmd_req_i(cmd_req), .cmd_addr_i(cmd_addr),
    .cmd_be_i(cmd_be), .cmd_type_i(cmd_type), .cmd_lock_i(cmd_lock),
    .cmd_ack_o(cmd_ack), .cmd_done_o(cmd_done), .cmd_err_o(cmd_err), .cmd_tmo_o(cmd_tmo),
    .st_data_i(st_data), .st_src_rdy_ni(st_src_rdy_n), .st_dst_rdy_no(dst_rdy_n),
    .st_dst_dsc_no(dst_dsc_n), .bus_req_o(bus_req), .bus_addr_o(bus_addr),
    .bus_be_o(bus_be), .bus_type_o(bus_type), .bus_lock_o(bus_lock),
    .bus_wrdata_o(bus_wrdata), .bus_addr_ack_i(addr_ack), .bus_tmo_i(tmo),
    .bus_wr_ack_i(wr_ack), .bus_wr_err_i(wr_err), .mst_err_o(mst_err)
  );

  // reference model: m_step 0 idle, 1 address wait, 2 data wait, 3 recovery
  int m_step = 0;
  logic [AW-1:0] m_addr = '0;
  logic [BEW-1:0] m_be = '0;
  logic [TW-1:0] m_type = '0;
  logic m_lock = 0, m_have = 0, m_err = 0;
  logic [DW-1:0] m_data = '0;
  logic m_ack = 0, m_done = 0, m_tmo = 0, m_cerr = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_have = 0; m_err = 0; m_ack = 0; m_done = 0; m_tmo = 0; m_cerr = 0;
      m_addr = '0; m_be = '0; m_type = '0; m_lock = 0; m_data = '0;
    end else begin
      automatic logic had = m_have;
      automatic int step = m_step;
      m_ack = 0; m_done = 0; m_tmo = 0; m_cerr = 0;
      if ((step == 1 || step == 2) && !had && !st_src_rdy_n) begin
        m_have = 1; m_data = st_data;
      end
      if (step == 0) begin
        m_have = 0;
        if (cmd_req) begin
          m_step = 1; m_ack = 1;
          m_addr = cmd_addr; m_be = cmd_be; m_type = cmd_type; m_lock = cmd_lock;
        end
      end else if (step == 1) begin
        if (tmo) begin
          m_step = 3; m_err = 1; m_done = 1; m_tmo = 1; m_cerr = 1;
        end else if (addr_ack) m_step = 2;
      end else if (step == 2) begin
        if (wr_ack && had) begin
          m_step = 0; m_done = 1; m_cerr = wr_err;
          if (wr_err) m_err = 1;
        end
      end else m_step = 0;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic rq = (m_step == 1);
      chk(bus_req, rq, "R2/R4 bus_req");
      chk(bus_addr, rq ? m_addr : '0, "R3/R4 bus_addr");
      chk(bus_be, rq ? m_be : '0, "R3/R4 bus_be");
      chk(bus_type, rq ? m_type : '0, "R4 bus_type");
      chk(bus_lock, rq ? m_lock : 1'b0, "R4 bus_lock");
      chk(bus_wrdata, (m_step == 2) ? m_data : '0, "R9 bus_wrdata");
      chk(dst_rdy_n, !((m_step == 1 || m_step == 2) && !m_have), "R8 dst_rdy");
      chk(dst_dsc_n, !(m_step == 3 && !m_have), "R7 dst_dsc");
      chk(mst_err, m_err, "R6 mst_err");
      chk({cmd_ack, cmd_done, cmd_tmo, cmd_err}, {m_ack, m_done, m_tmo, m_cerr}, "R5 pulses");
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic [BEW-1:0] b, input logic [TW-1:0] t, input logic l);
    @(negedge clk);
    cmd_req = 1; cmd_addr = a; cmd_be = b; cmd_type = t; cmd_lock = l;
    @(negedge clk);
    cmd_req = 0;
  endtask

  task automatic beat(input logic [DW-1:0] d);
    @(negedge clk); st_src_rdy_n = 0; st_data = d;
    @(negedge clk); st_src_rdy_n = 1;
  endtask

  task automatic pulse_addr_ack();
    @(negedge clk); addr_ack = 1;
    @(negedge clk); addr_ack = 0;
  endtask

  task automatic pulse_wr_ack(input logic e);
    @(negedge clk); wr_ack = 1; wr_err = e;
    @(negedge clk); wr_ack = 0; wr_err = 0;
  endtask

  task automatic pulse_tmo();
    @(negedge clk); tmo = 1;
    @(negedge clk); tmo = 0;
  endtask

  task automatic reset_pulse();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    tick(2);
    // R1 values held during reset
    chk({bus_req, mst_err, cmd_done, cmd_ack}, 4'b0, "R1 reset outputs");
    chk({dst_rdy_n, dst_dsc_n}, 2'b11, "R1 reset stream");
    rst_n = 1;
    tick(1);
    chk(bus_req, 0, "R1 after release");

    // normal write, word before the address acknowledge
    issue(32'h1000_0004, 4'hF, 3'd1, 1'b0);
    chk(cmd_ack, 1, "R2 command ack");
    chk(bus_addr, 32'h1000_0004, "R2 address driven");
    beat(32'hCAFE_0001);
    tick(2);
    chk(bus_req, 1, "R3 request held");
    pulse_addr_ack();
    chk(bus_wrdata, 32'hCAFE_0001, "R9 write data");
    pulse_wr_ack(0);
    chk({cmd_done, cmd_err, cmd_tmo}, 3'b100, "R9 done clean");

    // timeout with no word taken, next command held through recovery
    issue(32'h2000_0010, 4'h3, 3'd2, 1'b1);
    tick(1);
    @(negedge clk); tmo = 1; cmd_req = 1; cmd_addr = 32'h3000_0000; cmd_be = 4'hC;
    @(negedge clk); tmo = 0;
    chk({bus_req, bus_addr != 0, bus_lock}, 3'b000, "R4 request dropped");
    chk({cmd_done, cmd_tmo, cmd_err}, 3'b111, "R5 timeout status");
    chk(dst_dsc_n, 0, "R7 discontinue");
    chk(cmd_ack, 0, "R11 no ack in recovery");
    tick(1);
    chk(cmd_ack, 0, "R11 no ack idle after recovery");
    chk(mst_err, 1, "R6 error held");
    tick(1);
    chk(cmd_ack, 1, "R11 pending command accepted");
    cmd_req = 0;
    // early write ack before the word is ignored
    pulse_addr_ack();
    pulse_wr_ack(0);
    chk(cmd_done, 0, "R9 early ack ignored");
    beat(32'h0000_BEEF);
    pulse_wr_ack(0);
    chk(cmd_done, 1, "R9 done after word");
    chk(mst_err, 1, "R6 still held");

    reset_pulse();
    tick(1);
    chk(mst_err, 0, "R6 cleared by reset");

    // timeout after the word is taken: no discontinue
    issue(32'h1000_0004, 4'hF, 3'd0, 1'b0);
    beat(32'h1234_5678);
    pulse_tmo();
    chk({dst_dsc_n, cmd_tmo}, 2'b11, "R7 no discontinue once taken");

    // write error response
    reset_pulse();
    issue(32'h4000_0000, 4'h1, 3'd3, 1'b0);
    beat(32'h5555_AAAA);
    tick(1);
    chk(dst_rdy_n, 1, "R8 one word per command");
    pulse_addr_ack();
    pulse_wr_ack(1);
    chk({cmd_done, cmd_err, cmd_tmo}, 3'b110, "R10 write error status");
    tick(1);
    chk(mst_err, 1, "R10 error flag set");

    // timeout and address ack together
    reset_pulse();
    issue(32'h5000_0000, 4'hF, 3'd0, 1'b0);
    @(negedge clk); tmo = 1; addr_ack = 1;
    @(negedge clk); tmo = 0; addr_ack = 0;
    chk({cmd_tmo, bus_req}, 2'b10, "R12 timeout wins");
    tick(3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule